// File: doc/BRIEF.md
# Quadrature NCO and Complex Mixer

This block moves a channel of interest in a sampled 10-bit stream down to zero frequency. The stream can be real or complex. Every sample the block accepts is multiplied by a cosine/sine pair from a numerically controlled oscillator. The mixed result is rounded to 12 bits per rail and comes out with a one-cycle valid pulse. The oscillator advances by the sum of two 32-bit two's-complement words. The first is a carrier word that is copied from a holding input on a load strobe. The second is an offset word that a tracking loop streams in one bit per clock.

The output phase can be moved in two ways. A signed 8-bit static offset register gives steps of 1/256 of a turn. A 2-bit fast step input selects a quarter-turn shift and may change with every sample. The oscillator, the input capture and the mixer move only when the active-low sample qualifier is low. Because of this, the tuned frequency is set relative to the qualified sample rate and not the clock rate. A test output carries the most significant accumulator bit so the oscillator rate can be observed.

Top module: `qnco_mixer`

## Requirements
- R1: While reset is held, and afterwards until the first accepted sample has passed the pipeline, `out_i`, `out_q`, `out_vld` and `lo_msb` are 0. The phase accumulator restarts at 0, and the carrier and offset words restart at 0.
- R2: A sample is accepted at each rising edge where `in_en_n` is low. The sample is mixed with the phase the 32-bit accumulator holds before that edge. At the same edge the accumulator adds carrier+offset modulo 2^32. The table phase is accumulator bits 31..21, so one turn is 2048 steps. `lo_msb` shows accumulator bit 31.
- R3: At an edge where `in_en_n` is high, the accumulator does not move, no valid pulse is made, and `out_i`/`out_q` keep their last values.
- R4: A high `cf_load` at a rising edge copies `cf_hold` into the carrier word. The new word is used from the next edge onward. Changes on `cf_hold` without `cf_load` have no effect.
- R5: A pulse on `ofs_sync` at one edge starts an offset transfer. The 32 following edges each take one `ofs_bit`, MSB first. The assembled word replaces the offset at the 32nd bit edge. A sample accepted at that same edge, or earlier, still uses the previous offset.
- R6: A negative carrier+offset sum rotates the phase clockwise (decreasing). With sum 0xC0000000, consecutive samples see 0, 270, 180 and 90 degrees.
- R7: `ph_ofs` is an 8-bit two's-complement value PO. It adds 8·PO to the 11-bit phase, which is π·PO/128 radians. 0x20 gives +45 degrees and 0xE0 gives −45 degrees.
- R8: `ph_step` is sampled with each accepted sample and adds a quarter-turn shift. Code 00 gives 0, 01 gives 90, 10 gives 270 and 11 gives 180 degrees.
- R9: For table phase p, c = round(511·cos(2πp/2048)) and s = round(511·sin(2πp/2048)). Then `out_i` = floor((I·c − Q·s + 128)/256) and `out_q` = floor((I·s + Q·c + 128)/256), as 12-bit two's complement.
- R10: Results and a one-cycle `out_vld` pulse appear after the second rising edge that follows the accepting edge.
- R11: When `in_real` is 1 at the accepting edge, the Q input is taken as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_en_n | input | 1 | Sample qualifier, active low |
| in_real | input | 1 | 1: treat Q input as zero |
| in_i | input | 10 | In-phase sample, two's complement |
| in_q | input | 10 | Quadrature sample, two's complement |
| cf_hold | input | 32 | Carrier word holding value |
| cf_load | input | 1 | Copy `cf_hold` into the carrier word |
| ofs_sync | input | 1 | Start of serial offset word |
| ofs_bit | input | 1 | Serial offset data, MSB first |
| ph_ofs | input | 8 | Static phase offset, two's complement |
| ph_step | input | 2 | Fast quarter-turn phase step code |
| out_i | output | 12 | Mixed in-phase result |
| out_q | output | 12 | Mixed quadrature result |
| out_vld | output | 1 | One-cycle pulse marking a new result |
| lo_msb | output | 1 | Accumulator most significant bit |

## Verification
The hardest case to reach from the ports is a sample accepted on exactly the edge that takes the last serial offset bit. At that edge the new offset is being committed while the accumulator is adding. The stimulus drives the serial word bit by bit and lowers the sample qualifier only for the 32nd bit. A reference model still applies the old offset to that sample. Any early use of a partly shifted word then shows up as a large phase error in the sample that follows.

// File: rtl/qnco_pkg.sv
package qnco_pkg;

   // fast phase-step code -> quarter-turn count
   function automatic logic [1:0] step_quadrant(input logic [1:0] code);
      logic [1:0] quad;
      case (code)
         2'b00:   quad = 2'd0;
         2'b01:   quad = 2'd1;
         2'b10:   quad = 2'd3;
         default: quad = 2'd2;
      endcase
      return quad;
   endfunction

   // elaboration-time sine sample, rounded to nearest (symmetric)
   function automatic int sine_entry(input int k, input int n, input int amp);
      real ang;
      real v;
      ang = 6.283185307179586 * real'(k) / real'(n);
      v   = real'(amp) * $sin(ang);
      if (v >= 0.0) return $rtoi(v + 0.5);
      return -$rtoi(0.5 - v);
   endfunction

endpackage

// File: rtl/qnco_offset_rx.sv
module qnco_offset_rx #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync,
   input  logic             sbit,
   output logic [ACC_W-1:0] ofs
);
   localparam int CNT_W = $clog2(ACC_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ACC_W - 1);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic [ACC_W-2:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         sh_q   <= '0;
         ofs    <= '0;
      end else if (sync) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         sh_q <= {sh_q[ACC_W-3:0], sbit};
         if (cnt_q == LAST) begin
            ofs    <= {sh_q, sbit};
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R5: no partially received word ever reaches the adder
   assert_shadow_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sync || !busy_q || cnt_q != LAST) |=> $stable(ofs));

endmodule

// File: rtl/qnco_phase_acc.sv
module qnco_phase_acc #(
   parameter int ACC_W = 32,
   parameter int PH_W  = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [ACC_W-1:0] cf,
   input  logic [ACC_W-1:0] ofs,
   output logic [PH_W-1:0]  phase_hi,
   output logic             msb
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] inc;

   assign inc = cf + ofs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (adv) acc_q <= acc_q + inc;
   end

   assign phase_hi = acc_q[ACC_W-1 -: PH_W];
   assign msb      = acc_q[ACC_W-1];

   // R3: accumulator frozen between qualified samples
   assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(acc_q));

endmodule

// File: rtl/qnco_sincos.sv
module qnco_sincos #(
   parameter int PH_W         = 11,
   parameter int TRIG_W       = 10,
   parameter bit QUARTER_WAVE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [PH_W-1:0]          phase,
   output logic signed [TRIG_W-1:0] sin_v,
   output logic signed [TRIG_W-1:0] cos_v
);
   import qnco_pkg::*;

   localparam int QN  = 1 << (PH_W - 2);
   localparam int NT  = 4 * QN;
   localparam int AMP = (1 << (TRIG_W - 1)) - 1;

   if (QUARTER_WAVE) begin : g_quarter
      logic signed [TRIG_W-1:0] qtab [QN+1];
      for (genvar k = 0; k <= QN; k++) begin : g_ent
         localparam int V = sine_entry(k, NT, AMP);
         assign qtab[k] = TRIG_W'(V);
      end

      logic [1:0]               quad;
      logic [PH_W-3:0]          idx;
      logic [PH_W-2:0]          cidx;
      logic signed [TRIG_W-1:0] a_v, b_v, s_n, c_n;

      always_comb begin
         quad = phase[PH_W-1 -: 2];
         idx  = phase[PH_W-3:0];
         cidx = (PH_W-1)'(QN) - {1'b0, idx};
         a_v  = qtab[idx];
         b_v  = qtab[cidx];
         case (quad)
            2'd0:    begin s_n = a_v;  c_n = b_v;  end
            2'd1:    begin s_n = b_v;  c_n = -a_v; end
            2'd2:    begin s_n = -a_v; c_n = -b_v; end
            default: begin s_n = -b_v; c_n = a_v;  end
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sin_v <= '0;
            cos_v <= '0;
         end else begin
            sin_v <= s_n;
            cos_v <= c_n;
         end
      end

      // R9: table output stays on the circle's amplitude bound
      assert_trig_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (sin_v != TRIG_W'(-AMP-1)) && (cos_v != TRIG_W'(-AMP-1)));
   end else begin : g_full
      logic signed [TRIG_W-1:0] ftab [NT];
      for (genvar k = 0; k < NT; k++) begin : g_ent
         localparam int V = sine_entry(k, NT, AMP);
         assign ftab[k] = TRIG_W'(V);
      end

      logic [PH_W-1:0] cph;
      assign cph = phase + PH_W'(QN);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sin_v <= '0;
            cos_v <= '0;
         end else begin
            sin_v <= ftab[phase];
            cos_v <= ftab[cph];
         end
      end
   end

endmodule

// File: rtl/qnco_cmul.sv
module qnco_cmul #(
   parameter int DAT_W  = 10,
   parameter int TRIG_W = 10,
   parameter int OUT_W  = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld_in,
   input  logic signed [DAT_W-1:0]  d_i,
   input  logic signed [DAT_W-1:0]  d_q,
   input  logic signed [TRIG_W-1:0] cos_v,
   input  logic signed [TRIG_W-1:0] sin_v,
   output logic signed [OUT_W-1:0]  out_i,
   output logic signed [OUT_W-1:0]  out_q,
   output logic                     vld_out
);
   localparam int PW   = DAT_W + TRIG_W;
   localparam int SW   = PW + 1;
   localparam int SH   = PW - OUT_W;
   localparam int HALF = 1 << (SH - 1);

   logic signed [PW-1:0] p_ic, p_qs, p_is, p_qc;
   logic signed [SW-1:0] sum_i, sum_q;
   logic signed [OUT_W-1:0] rnd_i, rnd_q;

   always_comb begin
      p_ic  = d_i * cos_v;
      p_qs  = d_q * sin_v;
      p_is  = d_i * sin_v;
      p_qc  = d_q * cos_v;
      sum_i = SW'(p_ic) - SW'(p_qs);
      sum_q = SW'(p_is) + SW'(p_qc);
      rnd_i = OUT_W'((sum_i + SW'(HALF)) >>> SH);
      rnd_q = OUT_W'((sum_q + SW'(HALF)) >>> SH);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_i   <= '0;
         out_q   <= '0;
         vld_out <= 1'b0;
      end else begin
         vld_out <= vld_in;
         if (vld_in) begin
            out_i <= rnd_i;
            out_q <= rnd_q;
         end
      end
   end

   // R3: results hold while no sample is moving through
   assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_in |=> ($stable(out_i) && $stable(out_q)));

endmodule

// File: rtl/qnco_mixer.sv
module qnco_mixer #(
   parameter int ACC_W        = 32,
   parameter int PH_W         = 11,
   parameter int PO_W         = 8,
   parameter int DAT_W        = 10,
   parameter int TRIG_W       = 10,
   parameter int OUT_W        = 12,
   parameter bit QUARTER_WAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_en_n,
   input  logic              in_real,
   input  logic [DAT_W-1:0]  in_i,
   input  logic [DAT_W-1:0]  in_q,
   input  logic [ACC_W-1:0]  cf_hold,
   input  logic              cf_load,
   input  logic              ofs_sync,
   input  logic              ofs_bit,
   input  logic [PO_W-1:0]   ph_ofs,
   input  logic [1:0]        ph_step,
   output logic [OUT_W-1:0]  out_i,
   output logic [OUT_W-1:0]  out_q,
   output logic              out_vld,
   output logic              lo_msb
);
   import qnco_pkg::*;

   if (PH_W <= PO_W || PH_W < 3) begin : g_bad_phase
      $error("qnco_mixer: PH_W must exceed PO_W and be at least 3");
   end
   if (ACC_W < PH_W) begin : g_bad_acc
      $error("qnco_mixer: ACC_W must be at least PH_W");
   end
   if (OUT_W >= DAT_W + TRIG_W) begin : g_bad_out
      $error("qnco_mixer: OUT_W must be narrower than DAT_W+TRIG_W");
   end

   logic             take;
   logic [ACC_W-1:0] cf_q;
   logic [ACC_W-1:0] ofs_w;
   logic [PH_W-1:0]  acc_hi;
   logic [PH_W-1:0]  ph_addr;

   assign take = !in_en_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cf_q <= '0;
      else if (cf_load) cf_q <= cf_hold;
   end

   qnco_offset_rx #(.ACC_W(ACC_W)) u_ofs (
      .clk(clk), .rst_n(rst_n), .sync(ofs_sync), .sbit(ofs_bit), .ofs(ofs_w));

   qnco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .adv(take), .cf(cf_q), .ofs(ofs_w),
      .phase_hi(acc_hi), .msb(lo_msb));

   assign ph_addr = acc_hi
                  + {ph_ofs, {(PH_W-PO_W){1'b0}}}
                  + {step_quadrant(ph_step), {(PH_W-2){1'b0}}};

   // stage 0: capture sample and phase
   logic                    s0_vld, s1_vld;
   logic signed [DAT_W-1:0] s0_i, s0_q, s1_i, s1_q;
   logic [PH_W-1:0]         s0_ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s0_vld <= 1'b0;
         s0_i   <= '0;
         s0_q   <= '0;
         s0_ph  <= '0;
      end else begin
         s0_vld <= take;
         if (take) begin
            s0_i  <= in_i;
            s0_q  <= in_real ? '0 : in_q;
            s0_ph <= ph_addr;
         end
      end
   end

   // stage 1: table lookup, sample delayed alongside
   logic signed [TRIG_W-1:0] sin_v, cos_v;

   qnco_sincos #(.PH_W(PH_W), .TRIG_W(TRIG_W), .QUARTER_WAVE(QUARTER_WAVE)) u_trig (
      .clk(clk), .rst_n(rst_n), .phase(s0_ph), .sin_v(sin_v), .cos_v(cos_v));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_i   <= '0;
         s1_q   <= '0;
      end else begin
         s1_vld <= s0_vld;
         s1_i   <= s0_i;
         s1_q   <= s0_q;
      end
   end

   // stage 2: complex multiply and round
   logic signed [OUT_W-1:0] m_i, m_q;

   qnco_cmul #(.DAT_W(DAT_W), .TRIG_W(TRIG_W), .OUT_W(OUT_W)) u_mul (
      .clk(clk), .rst_n(rst_n), .vld_in(s1_vld), .d_i(s1_i), .d_q(s1_q),
      .cos_v(cos_v), .sin_v(sin_v), .out_i(m_i), .out_q(m_q), .vld_out(out_vld));

   assign out_i = m_i;
   assign out_q = m_q;

   // R4: carrier word changes only on a load strobe
   assert_cf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cf_load |=> $stable(cf_q));

   // R10: every accepted sample yields a valid pulse three edges on
   assert_latency_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ##3 out_vld);

   // R10: no valid pulse without a matching accepted sample
   assert_latency_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(take, 3));

endmodule

// File: tb/qnco_mixer_test.sv
`timescale 1ns/1ps
module qnco_mixer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_en_n = 1'b1;
   logic        in_real = 1'b0;
   logic [9:0]  in_i = '0;
   logic [9:0]  in_q = '0;
   logic [31:0] cf_hold = '0;
   logic        cf_load = 1'b0;
   logic        ofs_sync = 1'b0;
   logic        ofs_bit = 1'b0;
   logic [7:0]  ph_ofs = '0;
   logic [1:0]  ph_step = '0;
   logic [11:0] out_i, out_q;
   logic        out_vld, lo_msb;

   always #2 clk = ~clk;

   qnco_mixer uut (
      .clk(clk), .rst_n(rst_n), .in_en_n(in_en_n), .in_real(in_real),
      .in_i(in_i), .in_q(in_q), .cf_hold(cf_hold), .cf_load(cf_load),
      .ofs_sync(ofs_sync), .ofs_bit(ofs_bit), .ph_ofs(ph_ofs), .ph_step(ph_step),
      .out_i(out_i), .out_q(out_q), .out_vld(out_vld), .lo_msb(lo_msb));

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference model state
   logic [31:0] m_acc = '0;
   logic [31:0] m_cf  = '0;
   logic [31:0] m_ofs = '0;
   int pend_i, pend_q;

   // fields: {real, step, po, q, i}
   localparam int NV = 8;
   localparam logic [30:0] VEC [NV] = '{
      {1'b0, 2'b00, 8'h00, 10'(0),    10'(300)},
      {1'b0, 2'b00, 8'h00, 10'(-200), 10'(150)},
      {1'b0, 2'b01, 8'h00, 10'(100),  10'(-400)},
      {1'b0, 2'b10, 8'h13, 10'(511),  10'(511)},
      {1'b0, 2'b11, 8'hF0, 10'(-512), 10'(7)},
      {1'b1, 2'b00, 8'h40, 10'(-300), 10'(-250)},
      {1'b0, 2'b01, 8'h80, 10'(-512), 10'(-512)},
      {1'b1, 2'b10, 8'h7F, 10'(255),  10'(-1)}
   };

   function automatic int tb_trig(int p, bit want_sin);
      real a, v;
      a = 6.283185307179586 * real'(p) / 2048.0;
      v = 511.0 * (want_sin ? $sin(a) : $cos(a));
      if (v >= 0.0) return $rtoi(v + 0.5);
      return -$rtoi(0.5 - v);
   endfunction

   function automatic int step_off(logic [1:0] st);
      case (st)
         2'b00:   return 0;
         2'b01:   return 512;
         2'b10:   return 1536;
         default: return 1024;
      endcase
   endfunction

   task automatic chk(input int act, input int exp, input int tol, input string tag);
      int d;
      n_chk++;
      d = act - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // model a sample accepted now: uses pre-add phase, then advances
   task automatic model_take(input logic signed [9:0] si, input logic signed [9:0] sq,
                             input logic [7:0] po, input logic [1:0] st, input logic rl);
      int p, c, s, qi, ii;
      p  = (int'(m_acc[31:21]) + 8 * int'($signed(po)) + step_off(st)) & 2047;
      c  = tb_trig(p, 1'b0);
      s  = tb_trig(p, 1'b1);
      ii = int'(si);
      qi = rl ? 0 : int'(sq);
      pend_i = (ii * c - qi * s + 128) >>> 8;
      pend_q = (ii * s + qi * c + 128) >>> 8;
      m_acc  = m_acc + m_cf + m_ofs;
   endtask

   task automatic drive(input logic signed [9:0] si, input logic signed [9:0] sq,
                        input logic [7:0] po, input logic [1:0] st, input logic rl);
      in_i = si; in_q = sq; ph_ofs = po; ph_step = st; in_real = rl;
      in_en_n = 1'b0;
   endtask

   // one sample, checked across its whole pipeline passage
   task automatic run_sample(input logic signed [9:0] si, input logic signed [9:0] sq,
                             input logic [7:0] po, input logic [1:0] st, input logic rl,
                             input string tag);
      int hold_i, hold_q;
      @(negedge clk);
      drive(si, sq, po, st, rl);
      model_take(si, sq, po, st, rl);
      @(negedge clk);
      in_en_n = 1'b1;
      in_i = 10'h155; in_q = 10'h2AA; ph_step = 2'b11; ph_ofs = 8'h55;
      chk(int'(lo_msb), int'(m_acc[31]), 0, "R2 lo_msb");
      @(negedge clk);
      chk(int'(out_vld), 0, 0, "R10 early valid");
      @(negedge clk);
      chk(int'(out_vld), 1, 0, "R10 valid pulse");
      chk(int'($signed(out_i)), pend_i, 1, {tag, " out_i"});
      chk(int'($signed(out_q)), pend_q, 1, {tag, " out_q"});
      hold_i = int'($signed(out_i));
      hold_q = int'($signed(out_q));
      @(negedge clk);
      chk(int'(out_vld), 0, 0, "R10 pulse length");
      chk(int'($signed(out_i)), hold_i, 0, "R3 out_i held");
      chk(int'($signed(out_q)), hold_q, 0, "R3 out_q held");
   endtask

   task automatic load_cf(input logic [31:0] w);
      @(negedge clk);
      cf_hold = w; cf_load = 1'b1;
      @(negedge clk);
      cf_load = 1'b0;
      m_cf = w;
   endtask

   // serial offset; a sample is accepted on the edge taking the last bit
   task automatic shift_offset(input logic [31:0] w, input logic signed [9:0] si);
      @(negedge clk);
      ofs_sync = 1'b1;
      @(negedge clk);
      ofs_sync = 1'b0;
      for (int b = 31; b >= 0; b--) begin
         ofs_bit = w[b];
         if (b == 0) begin
            drive(si, 10'(0), 8'h00, 2'b00, 1'b0);
            model_take(si, 10'(0), 8'h00, 2'b00, 1'b0);
         end
         @(negedge clk);
         in_en_n = 1'b1;
      end
      m_ofs = w;
      @(negedge clk);
      @(negedge clk);
      chk(int'(out_vld), 1, 0, "R5 boundary sample valid");
      chk(int'($signed(out_i)), pend_i, 1, "R5 boundary sample out_i (old offset)");
      chk(int'($signed(out_q)), pend_q, 1, "R5 boundary sample out_q (old offset)");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      int lo_before;
      // R1 reset state
      repeat (4) @(negedge clk);
      chk(int'(out_i), 0, 0, "R1 out_i in reset");
      chk(int'(out_q), 0, 0, "R1 out_q in reset");
      chk(int'(out_vld), 0, 0, "R1 out_vld in reset");
      chk(int'(lo_msb), 0, 0, "R1 lo_msb in reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(int'(out_vld), 0, 0, "R1 out_vld after reset");

      // first sample uses phase 0 with zero words (R1), then quarter-turn carrier
      run_sample(10'(400), 10'(0), 8'h00, 2'b00, 1'b0, "R1 phase zero");
      load_cf(32'h4000_0000);
      for (int k = 0; k < 4; k++)
         run_sample(10'(400), 10'(0), 8'h00, 2'b00, 1'b0, "R2 quarter steps");

      // R4: holding value change without strobe is ignored
      @(negedge clk);
      cf_hold = 32'h1234_5678;
      repeat (3) @(negedge clk);
      run_sample(10'(400), 10'(0), 8'h00, 2'b00, 1'b0, "R4 no load strobe");
      run_sample(10'(400), 10'(0), 8'h00, 2'b00, 1'b0, "R4 no load strobe");

      // R3: qualifier high keeps accumulator and outputs still
      lo_before = int'(lo_msb);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         in_i = 10'(k * 37); in_q = 10'(k * 11); ph_step = 2'(k);
         chk(int'(out_vld), 0, 0, "R3 no valid while idle");
      end
      chk(int'(lo_msb), lo_before, 0, "R3 lo_msb idle");
      run_sample(10'(400), 10'(0), 8'h00, 2'b00, 1'b0, "R3 phase resumes");

      // vector walk at an irregular carrier
      load_cf(32'h0B40_0000);
      for (int v = 0; v < NV; v++)
         run_sample(VEC[v][9:0], VEC[v][19:10], VEC[v][27:20], VEC[v][29:28],
                    VEC[v][30], "R9 vector");

      // R7 static offset, R8 step codes, R11 real mode, at phase 0
      load_cf(32'h0000_0000);
      while (m_acc[31:21] != 11'd0) begin
         load_cf(32'h0000_0000 - m_acc);
         run_sample(10'(0), 10'(0), 8'h00, 2'b00, 1'b0, "R2 realign");
         load_cf(32'h0000_0000);
      end
      run_sample(10'(400), 10'(0), 8'h20, 2'b00, 1'b0, "R7 +45 deg");
      run_sample(10'(400), 10'(0), 8'hE0, 2'b00, 1'b0, "R7 -45 deg");
      run_sample(10'(400), 10'(0), 8'h00, 2'b01, 1'b0, "R8 code 01 = 90");
      run_sample(10'(400), 10'(0), 8'h00, 2'b10, 1'b0, "R8 code 10 = 270");
      run_sample(10'(400), 10'(0), 8'h00, 2'b11, 1'b0, "R8 code 11 = 180");
      run_sample(10'(-512), 10'(-512), 8'h00, 2'b00, 1'b0, "R9 full-scale corner");
      run_sample(10'(-512), 10'(511), 8'h00, 2'b01, 1'b0, "R9 full-scale corner");
      run_sample(10'(300), 10'(300), 8'h00, 2'b01, 1'b1, "R11 real input");

      // R5 serial offset with boundary sample, then R6 clockwise rotation
      shift_offset(32'hC000_0000, 10'(400));
      for (int k = 0; k < 4; k++)
         run_sample(10'(400), 10'(0), 8'h00, 2'b00, 1'b0, "R6 clockwise");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule